// File: doc/BRIEF.md
# Accelerator Launch Register Slave

This block is the register front end of a compute engine that multiplies a matrix by a vector. A host reaches it over an AXI4-Lite port with a 6-bit byte address and a 32-bit data bus. Through it the host loads three 64-bit buffer addresses (the output buffer, the matrix and the vector), each held as a low and a high 32-bit word. It then launches the engine by setting a start bit and polls a control word until the engine reports completion.

Toward the engine the block drives the three assembled 64-bit addresses and a start level. It takes back a done pulse, a live idle level and a ready pulse that means the engine has taken the run. The control word combines the start request, a done flag that clears when read, the live idle level and a sticky ready flag.

Top module: `mxv_ctl_slave`

## Requirements
- R1: After reset all three address outputs are zero, `eng_start` is low, `s_bvalid` and `s_rvalid` are low, and `s_awready`, `s_wready` and `s_arready` are high.
- R2: A write to byte offset 0x10/0x14 sets the low/high half of `ptr_out`. A write to 0x1C/0x20 sets the low/high half of `ptr_mat`. A write to 0x28/0x2C sets the low/high half of `ptr_vec`. Other halves keep their values.
- R3: Reads of the six address words and of any unmapped offset return 0.
- R4: The address and data phases of a write may be accepted in either order or together. No register changes until both have been accepted. Exactly one write response follows.
- R5: Every write response and every read response carries OKAY (0).
- R6: The control word is at offset 0x00. Writing 1 to bit 0 raises `eng_start`. Writing 0 to bit 0 has no effect. `eng_start` stays high until `eng_ready` is sampled high, then falls on that clock edge.
- R7: Control bit 1 (done) is set by an `eng_done` pulse and cleared by a read of the control word. So after one run it reads 1 once and then 0. Host writes do not change it.
- R8: Control bit 2 returns the current level of `eng_idle`.
- R9: Control bit 3 (ready) is set by an `eng_ready` pulse and cleared by a read of the control word.
- R10: Once `s_bvalid` or `s_rvalid` is high, it stays high until its ready is seen. `s_rdata` does not change while it is held.
- R11: If an `eng_done` pulse lands on the same clock edge as the acceptance of a control-word read, that read returns done as 0. The flag stays set for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 6 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_start | output | 1 | Run request to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_idle | input | 1 | Engine idle level |
| eng_ready | input | 1 | Engine accepted-run pulse |
| ptr_out | output | 64 | Output buffer address |
| ptr_mat | output | 64 | Matrix address |
| ptr_vec | output | 64 | Vector address |

## Verification
The hardest case to reach is a done pulse that arrives on the very edge where a control-word read is accepted. Here the clear and the set collide, and a wrong priority silently loses a completion. The bench reaches it by raising `s_arvalid` and `eng_done` in the same half-cycle while the read channel is known to be idle. It then reads twice. The split write is the other hard case. The data phase is held alone for several cycles, and the outputs are checked to stay unchanged before the address phase arrives.

// File: rtl/mxv_ctl_pkg.sv
package mxv_ctl_pkg;
  localparam int NSLOT  = 6;
  localparam int SLOT_W = 3;
  localparam int WIDX_W = 4;

  localparam logic [SLOT_W-1:0] SL_OUT_LO = 3'd0;
  localparam logic [SLOT_W-1:0] SL_OUT_HI = 3'd1;
  localparam logic [SLOT_W-1:0] SL_MAT_LO = 3'd2;
  localparam logic [SLOT_W-1:0] SL_MAT_HI = 3'd3;
  localparam logic [SLOT_W-1:0] SL_VEC_LO = 3'd4;
  localparam logic [SLOT_W-1:0] SL_VEC_HI = 3'd5;
  localparam logic [SLOT_W-1:0] SL_NONE   = 3'd7;

  localparam logic [WIDX_W-1:0] CTRL_WIDX = 4'd0;
  localparam logic [1:0]        RESP_OKAY = 2'b00;

  // word index (byte offset / 4) to address slot
  function automatic logic [SLOT_W-1:0] slot_of(input logic [WIDX_W-1:0] w);
    case (w)
      4'd4:    slot_of = SL_OUT_LO;
      4'd5:    slot_of = SL_OUT_HI;
      4'd7:    slot_of = SL_MAT_LO;
      4'd8:    slot_of = SL_MAT_HI;
      4'd10:   slot_of = SL_VEC_LO;
      4'd11:   slot_of = SL_VEC_HI;
      default: slot_of = SL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mxv_wr_path.sv
module mxv_wr_path #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-3:0] awidx,
  input  logic          awvalid,
  output logic          awready,
  input  logic [DW-1:0] wdata,
  input  logic          wvalid,
  output logic          wready,
  output logic          bvalid,
  input  logic          bready,
  output logic          commit,
  output logic [AW-3:0] commit_idx,
  output logic [DW-1:0] commit_data
);
  logic          aw_have_q, aw_have_d, w_have_q, w_have_d, bvalid_q, bvalid_d;
  logic [AW-3:0] idx_q;
  logic [DW-1:0] data_q;
  logic          aw_fire, w_fire;

  assign awready = !aw_have_q && !bvalid_q;
  assign wready  = !w_have_q && !bvalid_q;
  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign commit  = aw_have_q && w_have_q;

  always_comb begin
    aw_have_d = commit ? 1'b0 : (aw_have_q || aw_fire);
    w_have_d  = commit ? 1'b0 : (w_have_q || w_fire);
    bvalid_d  = commit ? 1'b1 : (bvalid_q && !bready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_have_q <= 1'b0;
      w_have_q  <= 1'b0;
      bvalid_q  <= 1'b0;
    end else begin
      aw_have_q <= aw_have_d;
      w_have_q  <= w_have_d;
      bvalid_q  <= bvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (aw_fire) idx_q <= awidx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (w_fire) data_q <= wdata;
  end

  assign bvalid      = bvalid_q;
  assign commit_idx  = idx_q;
  assign commit_data = data_q;
endmodule

// File: rtl/mxv_rd_path.sv
module mxv_rd_path #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arvalid,
  output logic          arready,
  output logic          rd_fire,
  input  logic [DW-1:0] rd_word,
  output logic          rvalid,
  input  logic          rready,
  output logic [DW-1:0] rdata
);
  logic          rvalid_q, rvalid_d;
  logic [DW-1:0] rdata_q;

  assign arready = !rvalid_q;
  assign rd_fire = arvalid && arready;

  always_comb rvalid_d = rd_fire ? 1'b1 : (rvalid_q && !rready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_word;
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/mxv_regs.sv
module mxv_regs
  import mxv_ctl_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_commit,
  input  logic [AW-3:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_fire,
  input  logic [AW-3:0] rd_idx,
  output logic [DW-1:0] rd_word,
  input  logic          eng_done,
  input  logic          eng_idle,
  input  logic          eng_ready,
  output logic          eng_start,
  output logic [2*DW-1:0] ptr_out,
  output logic [2*DW-1:0] ptr_mat,
  output logic [2*DW-1:0] ptr_vec
);
  logic [DW-1:0]     ptr_q [NSLOT];
  logic [SLOT_W-1:0] wr_slot;
  logic              ctrl_wr, ctrl_rd;
  logic              start_q, start_d, done_q, done_d, rdy_q, rdy_d;

  assign wr_slot = slot_of(WIDX_W'(wr_idx));
  assign ctrl_wr = wr_commit && (WIDX_W'(wr_idx) == CTRL_WIDX);
  assign ctrl_rd = rd_fire && (WIDX_W'(rd_idx) == CTRL_WIDX);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic en;
    assign en = wr_commit && (wr_slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else if (en) ptr_q[g] <= wr_data;
    end
  end

  // set has priority over clear for done and ready; a host start request wins over ready
  always_comb begin
    start_d = start_q;
    if (ctrl_wr && wr_data[0]) start_d = 1'b1;
    else if (eng_ready)        start_d = 1'b0;
    done_d = eng_done  ? 1'b1 : (ctrl_rd ? 1'b0 : done_q);
    rdy_d  = eng_ready ? 1'b1 : (ctrl_rd ? 1'b0 : rdy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      rdy_q   <= rdy_d;
    end
  end

  always_comb begin
    if (WIDX_W'(rd_idx) == CTRL_WIDX)
      rd_word = {{(DW-4){1'b0}}, rdy_q, eng_idle, done_q, start_q};
    else
      rd_word = '0;
  end

  assign eng_start = start_q;
  assign ptr_out   = {ptr_q[SL_OUT_HI], ptr_q[SL_OUT_LO]};
  assign ptr_mat   = {ptr_q[SL_MAT_HI], ptr_q[SL_MAT_LO]};
  assign ptr_vec   = {ptr_q[SL_VEC_HI], ptr_q[SL_VEC_LO]};
endmodule

// File: rtl/mxv_ctl_slave.sv
module mxv_ctl_slave
  import mxv_ctl_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] s_awaddr,
  input  logic          s_awvalid,
  output logic          s_awready,
  input  logic [DW-1:0] s_wdata,
  input  logic          s_wvalid,
  output logic          s_wready,
  output logic [1:0]    s_bresp,
  output logic          s_bvalid,
  input  logic          s_bready,
  input  logic [AW-1:0] s_araddr,
  input  logic          s_arvalid,
  output logic          s_arready,
  output logic [DW-1:0] s_rdata,
  output logic [1:0]    s_rresp,
  output logic          s_rvalid,
  input  logic          s_rready,
  output logic          eng_start,
  input  logic          eng_done,
  input  logic          eng_idle,
  input  logic          eng_ready,
  output logic [2*DW-1:0] ptr_out,
  output logic [2*DW-1:0] ptr_mat,
  output logic [2*DW-1:0] ptr_vec
);
  localparam int IW = AW - 2;

  logic          rst_s1, rst_sn;
  logic          commit, rd_fire;
  logic [IW-1:0] commit_idx;
  logic [DW-1:0] commit_data, rd_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  mxv_wr_path #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_sn),
    .awidx(s_awaddr[AW-1:2]), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .commit(commit), .commit_idx(commit_idx), .commit_data(commit_data)
  );

  mxv_rd_path #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_sn),
    .arvalid(s_arvalid), .arready(s_arready), .rd_fire(rd_fire),
    .rd_word(rd_word), .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata)
  );

  mxv_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .wr_commit(commit), .wr_idx(commit_idx), .wr_data(commit_data),
    .rd_fire(rd_fire), .rd_idx(s_araddr[AW-1:2]), .rd_word(rd_word),
    .eng_done(eng_done), .eng_idle(eng_idle), .eng_ready(eng_ready),
    .eng_start(eng_start),
    .ptr_out(ptr_out), .ptr_mat(ptr_mat), .ptr_vec(ptr_vec)
  );

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;
endmodule

// File: rtl/mxv_ctl_slave_chk.sv
module mxv_ctl_slave_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            s_bvalid,
  input logic            s_bready,
  input logic [1:0]      s_bresp,
  input logic            s_rvalid,
  input logic            s_rready,
  input logic [DW-1:0]   s_rdata,
  input logic [1:0]      s_rresp,
  input logic            eng_start,
  input logic            eng_ready,
  input logic [2*DW-1:0] ptr_out,
  input logic [2*DW-1:0] ptr_mat,
  input logic [2*DW-1:0] ptr_vec
);
  a_r10_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);

  a_r10_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  a_r5_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> s_bresp == 2'b00);

  a_r5_rresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == 2'b00);

  a_r6_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !eng_ready |=> eng_start);

  a_r4_ptr_only_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(s_bvalid) |-> ($stable(ptr_out) && $stable(ptr_mat) && $stable(ptr_vec)));
endmodule

bind mxv_ctl_slave mxv_ctl_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
  .eng_start(eng_start), .eng_ready(eng_ready),
  .ptr_out(ptr_out), .ptr_mat(ptr_mat), .ptr_vec(ptr_vec)
);

// File: tb/mxv_ctl_slave_tb.sv
`timescale 1ns/1ps
module mxv_ctl_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  s_awaddr, s_araddr;
  logic        s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
  logic [31:0] s_wdata, s_rdata;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic        eng_start, eng_done, eng_idle, eng_ready;
  logic [63:0] ptr_out, ptr_mat, ptr_vec;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] mdl [6];

  always #2 clk = ~clk;

  mxv_ctl_slave u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slot per requirement R2 offsets: 0x10,0x14,0x1C,0x20,0x28,0x2C
  function automatic int slot_of(input logic [5:0] a);
    case (a)
      6'h10: return 0; 6'h14: return 1; 6'h1C: return 2;
      6'h20: return 3; 6'h28: return 4; 6'h2C: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic check_ptrs(input string tag);
    chk(ptr_out == {mdl[1], mdl[0]}, tag, ptr_out, {mdl[1], mdl[0]});
    chk(ptr_mat == {mdl[3], mdl[2]}, tag, ptr_mat, {mdl[3], mdl[2]});
    chk(ptr_vec == {mdl[5], mdl[4]}, tag, ptr_vec, {mdl[5], mdl[4]});
  endtask

  task automatic do_aw(input logic [5:0] a);
    s_awaddr = a; s_awvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk); s_awvalid = 1'b0;
  endtask

  task automatic do_w(input logic [31:0] d);
    s_wdata = d; s_wvalid = 1'b1;
    while (!s_wready) @(negedge clk);
    @(negedge clk); s_wvalid = 1'b0;
  endtask

  task automatic axi_write(input logic [5:0] a, input logic [31:0] d, input int order);
    if (order == 0) begin
      do_aw(a);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      do_w(d);
    end else if (order == 1) begin
      do_w(d);
      repeat (3) @(negedge clk);
      check_ptrs("R4 no change before address phase");
      do_aw(a);
    end else begin
      s_awaddr = a; s_awvalid = 1'b1; s_wdata = d; s_wvalid = 1'b1;
      @(negedge clk); s_awvalid = 1'b0; s_wvalid = 1'b0;
    end
    repeat ($urandom_range(0, 3)) @(negedge clk);
    s_bready = 1'b1;
    while (!s_bvalid) @(negedge clk);
    chk(s_bresp == 2'b00, "R5 bresp", 64'(s_bresp), 64'd0);
    @(negedge clk); s_bready = 1'b0;
    chk(!s_bvalid, "R4 single response", 64'(s_bvalid), 64'd0);
    if (slot_of(a) >= 0) mdl[slot_of(a)] = d;
  endtask

  task automatic axi_read(input logic [5:0] a, output logic [31:0] d);
    s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk); s_arvalid = 1'b0;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    s_rready = 1'b1;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    chk(s_rresp == 2'b00, "R5 rresp", 64'(s_rresp), 64'd0);
    @(negedge clk); s_rready = 1'b0;
  endtask

  task automatic pulse_ready();
    eng_ready = 1'b1; @(negedge clk); eng_ready = 1'b0;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    process::self().srandom(32'd1234);
    rst_n = 1'b0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0;
    s_awvalid = 0; s_wvalid = 0; s_bready = 0; s_arvalid = 0; s_rready = 0;
    eng_done = 0; eng_idle = 1; eng_ready = 0;
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_ptrs("R1 reset pointers");
    chk(!eng_start, "R1 start low", 64'(eng_start), 0);
    chk(!s_bvalid && !s_rvalid, "R1 no responses", {s_bvalid, s_rvalid}, 0);
    chk(s_awready && s_wready && s_arready, "R1 readies",
        {s_awready, s_wready, s_arready}, 3'b111);

    // R2/R4 directed: every slot, every order
    for (int k = 0; k < 6; k++) begin
      logic [5:0] a;
      a = (k == 0) ? 6'h10 : (k == 1) ? 6'h14 : (k == 2) ? 6'h1C :
          (k == 3) ? 6'h20 : (k == 4) ? 6'h28 : 6'h2C;
      axi_write(a, 32'hA5000000 | 32'(k), k % 3);
      check_ptrs("R2 directed pointer write");
    end

    // R2/R4 random writes including unmapped offsets
    for (int k = 0; k < 24; k++) begin
      logic [5:0] a;
      a = 6'($urandom_range(1, 15) << 2);
      axi_write(a, $urandom, $urandom_range(0, 2));
      check_ptrs("R2 random write");
      chk(!eng_start, "R6 no stray start", 64'(eng_start), 0);
    end

    // R3 reads return zero for pointer and unmapped words
    for (int k = 1; k < 16; k++) begin
      axi_read(6'(k << 2), rd);
      chk(rd == 0, "R3 read zero", 64'(rd), 0);
    end

    // R6..R9 runs with random engine delays
    for (int run = 0; run < 4; run++) begin
      eng_idle = 1'b1;
      axi_read(6'h00, rd);
      chk(rd == 32'h4, "R8 idle visible", 64'(rd), 64'h4);
      axi_write(6'h00, 32'h0000_0001, run % 3);
      chk(eng_start, "R6 start raised", 64'(eng_start), 1);
      eng_idle = 1'b0;
      repeat ($urandom_range(1, 10)) @(negedge clk);
      chk(eng_start, "R6 start held", 64'(eng_start), 1);
      axi_read(6'h00, rd);
      chk(rd == 32'h1, "R8 busy and start", 64'(rd), 64'h1);
      pulse_ready();
      chk(!eng_start, "R6 start cleared by ready", 64'(eng_start), 0);
      repeat ($urandom_range(1, 20)) @(negedge clk);
      pulse_done();
      eng_idle = 1'b1;
      axi_read(6'h00, rd);
      chk(rd == 32'hE, "R7 R9 done and ready set", 64'(rd), 64'hE);
      axi_read(6'h00, rd);
      chk(rd == 32'h4, "R7 R9 cleared on read", 64'(rd), 64'h4);
    end

    // R6/R7: writing 0 to start and 1 to done/ready bits does nothing
    axi_write(6'h00, 32'hFFFF_FFFE, 2);
    chk(!eng_start, "R6 write zero no effect", 64'(eng_start), 0);
    axi_read(6'h00, rd);
    chk(rd == 32'h4, "R7 host cannot set done", 64'(rd), 64'h4);

    // R11: done pulse on the edge a control read is accepted
    s_araddr = 6'h00; s_arvalid = 1'b1; eng_done = 1'b1;
    @(negedge clk); s_arvalid = 1'b0; eng_done = 1'b0;
    s_rready = 1'b1;
    while (!s_rvalid) @(negedge clk);
    rd = s_rdata;
    @(negedge clk); s_rready = 1'b0;
    chk(rd[1] == 1'b0, "R11 colliding read sees old done", 64'(rd), 64'h4);
    axi_read(6'h00, rd);
    chk(rd[1] == 1'b1, "R11 done kept", 64'(rd), 64'h6);
    axi_read(6'h00, rd);
    chk(rd[1] == 1'b0, "R7 done read once", 64'(rd), 64'h4);

    check_ptrs("R2 pointers retained");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule